// File: doc/BRIEF.md
# Memory Barrier Drain Controller

This block stalls the pipeline for a full memory-ordering barrier in a simple in-order core. When decode recognises a barrier, the controller raises a dispatch stall that keeps every younger instruction from starting. It releases that stall only after all older work has drained:

- every older instruction has moved past the stage where it could still trap;
- every older load and store has been performed;
- every older cache-touch hint has finished address translation.

Touch hints do not have to finish on the bus.

Outstanding work is tracked by one saturating up/down counter per class of work. The pipeline feeds these counters with single-cycle pulses. A start pulse raises a class's count. A matching completion pulse lowers it.

When all counters read zero while a barrier waits, the controller gives a one-cycle completion pulse and drops the stall in that same cycle. The barrier itself starts no transaction of any kind, so the block has no bus-side port. The stall length follows from how much older work is in flight when the barrier arrives.

Top module: `mem_barrier_drain`

## Requirements
- R1: After reset, `dispatch_stall` and `barrier_done` are 0 and all three outstanding counts are zero.
- R2: A barrier that arrives with nothing outstanding gives exactly one cycle of `dispatch_stall`. In the next cycle `barrier_done` is 1 and `dispatch_stall` is 0.
- R3: While any older instruction has issued (`instr_issue`) but not yet signalled `instr_safe`, the stall stays high and `barrier_done` stays 0.
- R4: While any load or store has been requested (`mem_req`) but not yet signalled `mem_done`, the stall stays high and `barrier_done` stays 0.
- R5: A touch hint counts as outstanding only from `touch_req` until `touch_xlated`. Once it is translated it no longer holds the barrier, and no bus completion is needed.
- R6: `barrier_done` is high for exactly one cycle. It is high only in the cycle in which `dispatch_stall` falls from 1 to 0.
- R7: A second barrier pulse while a barrier is pending is ignored. It causes no extra stall and no second `barrier_done`.
- R8: Start pulses that arrive in the same cycle as the barrier count as older work and hold the barrier.
- R9: A completion pulse for a class whose count is zero is ignored. The count does not wrap.
- R10: A start pulse and a completion pulse for the same class in the same cycle leave that count unchanged.
- R11: Each class holds up to 15 outstanding items (4-bit count). A barrier is released only after all 15 have completed.
- R12: `barrier_done` rises in the cycle after the last outstanding count reaches zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| barrier_dec | input | 1 | Pulse: a barrier op has been decoded |
| instr_issue | input | 1 | Pulse: an instruction has issued |
| instr_safe | input | 1 | Pulse: an instruction has passed its last trap point |
| mem_req | input | 1 | Pulse: a load or store has started |
| mem_done | input | 1 | Pulse: a load or store has been performed |
| touch_req | input | 1 | Pulse: a cache-touch hint has started |
| touch_xlated | input | 1 | Pulse: a touch hint has finished address translation |
| dispatch_stall | output | 1 | Holds younger instructions out of dispatch |
| barrier_done | output | 1 | One-cycle pulse when the barrier completes |

## Verification
The assertions check the following on every cycle:

- the completion pulse lasts one cycle and coincides with the stall falling;
- a pending barrier never drains while any counter is non-zero;
- each counter neither wraps below zero nor changes on a simultaneous start and completion;
- no counter is pushed past its capacity.

Only the directed scenarios can show the rest:

- the exact latency from the last completion to release;
- that same-cycle starts count as older work;
- that a repeated barrier yields no extra pulse;
- that a counter filled to 15 needs all 15 completions before it releases.

// File: rtl/mbd_pkg.sv
package mbd_pkg;

  localparam int NUM_CLS = 3;

  typedef enum logic [1:0] {
    CLS_INSTR = 2'd0,
    CLS_MEM   = 2'd1,
    CLS_TOUCH = 2'd2
  } cls_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_PEND = 1'b1
  } bar_st_e;

endpackage

// File: rtl/mbd_counter.sv
module mbd_counter #(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic dec,
  output logic zero
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_ONE;
        2'b01:   if (cnt_q != '0)      cnt_q <= cnt_q - CNT_ONE;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign zero = (cnt_q == '0);

  // R11: upstream must never exceed the counter capacity
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX) |-> !(inc && !dec));

  // R9: completion at zero leaves the count at zero
  p_no_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    ((cnt_q == '0) && dec && !inc) |=> (cnt_q == '0));

  // R10: start and completion together hold the count
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (inc && dec) |=> $stable(cnt_q));

endmodule

// File: rtl/mbd_seq.sv
module mbd_seq
  import mbd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic barrier_dec,
  input  logic drained,
  output logic stall_o,
  output logic done_o
);

  bar_st_e st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        ST_IDLE: if (barrier_dec) st_q <= ST_PEND;
        ST_PEND: begin
          // a repeated barrier_dec here is deliberately ignored
          if (drained) begin
            st_q   <= ST_IDLE;
            done_o <= 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign stall_o = (st_q == ST_PEND);

  // R3, R4: a pending barrier cannot drain while work is outstanding
  p_hold_until_drained_r3: assert property (@(posedge clk) disable iff (rst)
    (stall_o && !drained) |=> (stall_o && !done_o));

  // R6: completion lasts one cycle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R6: completion coincides with the stall falling
  p_done_release_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!stall_o && $past(stall_o)));

endmodule

// File: rtl/mem_barrier_drain.sv
module mem_barrier_drain
  import mbd_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic barrier_dec,
  input  logic instr_issue,
  input  logic instr_safe,
  input  logic mem_req,
  input  logic mem_done,
  input  logic touch_req,
  input  logic touch_xlated,
  output logic dispatch_stall,
  output logic barrier_done
);

  logic [NUM_CLS-1:0] inc_v;
  logic [NUM_CLS-1:0] dec_v;
  logic [NUM_CLS-1:0] zero_v;
  logic               drained;

  always_comb begin
    inc_v            = '0;
    dec_v            = '0;
    inc_v[CLS_INSTR] = instr_issue;
    dec_v[CLS_INSTR] = instr_safe;
    inc_v[CLS_MEM]   = mem_req;
    dec_v[CLS_MEM]   = mem_done;
    inc_v[CLS_TOUCH] = touch_req;
    dec_v[CLS_TOUCH] = touch_xlated;
  end

  for (genvar g = 0; g < NUM_CLS; g++) begin : g_cls
    mbd_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst  (rst),
      .inc  (inc_v[g]),
      .dec  (dec_v[g]),
      .zero (zero_v[g])
    );
  end

  assign drained = &zero_v;

  mbd_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .barrier_dec (barrier_dec),
    .drained     (drained),
    .stall_o     (dispatch_stall),
    .done_o      (barrier_done)
  );

  // R2: a barrier from idle raises the stall on the next cycle
  p_stall_rise_r2: assert property (@(posedge clk) disable iff (rst)
    (!dispatch_stall && barrier_dec) |=> dispatch_stall);

  // R6: no completion pulse without a preceding stall
  p_done_needs_stall_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(barrier_done) |-> $past(dispatch_stall));

endmodule

// File: tb/mem_barrier_drain_tb.sv
`timescale 1ns/1ps
module mem_barrier_drain_tb;

  localparam logic [6:0] P_BAR   = 7'b1000000;
  localparam logic [6:0] P_ISS   = 7'b0100000;
  localparam logic [6:0] P_SAFE  = 7'b0010000;
  localparam logic [6:0] P_MREQ  = 7'b0001000;
  localparam logic [6:0] P_MDONE = 7'b0000100;
  localparam logic [6:0] P_TREQ  = 7'b0000010;
  localparam logic [6:0] P_TXL   = 7'b0000001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic barrier_dec = 1'b0, instr_issue = 1'b0, instr_safe = 1'b0;
  logic mem_req = 1'b0, mem_done = 1'b0, touch_req = 1'b0, touch_xlated = 1'b0;
  logic dispatch_stall, barrier_done;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  mem_barrier_drain u_dut (
    .clk(clk), .rst(rst), .barrier_dec(barrier_dec),
    .instr_issue(instr_issue), .instr_safe(instr_safe),
    .mem_req(mem_req), .mem_done(mem_done),
    .touch_req(touch_req), .touch_xlated(touch_xlated),
    .dispatch_stall(dispatch_stall), .barrier_done(barrier_done)
  );

  task automatic chk(input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", what, act, exp);
    end
  endtask

  // drive pulses for one cycle; returns at the negedge after the sampling edge
  task automatic pulse(input logic [6:0] v);
    {barrier_dec, instr_issue, instr_safe, mem_req, mem_done, touch_req, touch_xlated} = v;
    @(negedge clk);
    {barrier_dec, instr_issue, instr_safe, mem_req, mem_done, touch_req, touch_xlated} = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
  endtask

  // called right after the pulse that empties the last counter (R12)
  task automatic expect_release(input string tag);
    chk(dispatch_stall, 1'b1, {tag, " stall before release"});
    chk(barrier_done, 1'b0, {tag, " no done before release"});
    @(negedge clk);
    chk(barrier_done, 1'b1, {tag, " R12 done one cycle after drain"});
    chk(dispatch_stall, 1'b0, {tag, " R6 stall falls with done"});
    @(negedge clk);
    chk(barrier_done, 1'b0, {tag, " R6 done single cycle"});
    chk(dispatch_stall, 1'b0, {tag, " stall stays low"});
  endtask

  task automatic hold_check(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      chk(dispatch_stall, 1'b1, {tag, " stall held"});
      chk(barrier_done, 1'b0, {tag, " done held low"});
      @(negedge clk);
    end
  endtask

  task automatic t_reset_r1();
    do_reset();
    chk(dispatch_stall, 1'b0, "R1 stall after reset");
    chk(barrier_done, 1'b0, "R1 done after reset");
    pulse(P_BAR);   // zero counts -> R2 timing
    chk(dispatch_stall, 1'b1, "R1 counts zero: one stall cycle");
    @(negedge clk);
    chk(barrier_done, 1'b1, "R1 counts zero: done next cycle");
    idle(1);
  endtask

  task automatic t_empty_r2();
    do_reset();
    pulse(P_BAR);
    chk(dispatch_stall, 1'b1, "R2 stall raised");
    chk(barrier_done, 1'b0, "R2 done not yet");
    @(negedge clk);
    chk(barrier_done, 1'b1, "R2 done");
    chk(dispatch_stall, 1'b0, "R2 stall released");
    @(negedge clk);
    chk(barrier_done, 1'b0, "R2 done one cycle");
  endtask

  task automatic t_instr_r3();
    do_reset();
    pulse(P_ISS); pulse(P_ISS);
    pulse(P_BAR);
    hold_check(4, "R3");
    pulse(P_SAFE);
    hold_check(3, "R3 one left");
    pulse(P_SAFE);
    expect_release("R3");
  endtask

  task automatic t_mem_r4();
    do_reset();
    pulse(P_MREQ);
    pulse(P_BAR);
    hold_check(5, "R4");
    pulse(P_MDONE);
    expect_release("R4");
  endtask

  task automatic t_touch_r5();
    do_reset();
    pulse(P_TREQ);
    pulse(P_BAR);
    hold_check(3, "R5 untranslated");
    pulse(P_TXL);
    expect_release("R5");
  endtask

  task automatic t_second_r7();
    do_reset();
    pulse(P_MREQ);
    pulse(P_BAR);
    hold_check(2, "R7");
    pulse(P_BAR);
    hold_check(2, "R7 after repeat");
    pulse(P_MDONE);
    expect_release("R7");
    for (int i = 0; i < 5; i++) begin
      chk(barrier_done, 1'b0, "R7 no second done");
      chk(dispatch_stall, 1'b0, "R7 no second stall");
      @(negedge clk);
    end
  endtask

  task automatic t_same_cycle_r8();
    do_reset();
    pulse(P_BAR | P_ISS | P_MREQ);
    hold_check(3, "R8");
    pulse(P_SAFE);
    hold_check(2, "R8 mem still out");
    pulse(P_MDONE);
    expect_release("R8");
  endtask

  task automatic t_underflow_r9();
    do_reset();
    pulse(P_SAFE);
    pulse(P_MDONE | P_TXL);
    pulse(P_ISS);   // count must be 1, not 0 after a wrap to 15
    pulse(P_BAR);
    hold_check(3, "R9");
    pulse(P_SAFE);
    expect_release("R9");
  endtask

  task automatic t_simul_r10();
    do_reset();
    pulse(P_ISS);
    pulse(P_ISS | P_SAFE);
    pulse(P_BAR);
    hold_check(3, "R10");
    pulse(P_SAFE);
    expect_release("R10");
  endtask

  task automatic t_full_r11();
    do_reset();
    for (int i = 0; i < 15; i++) pulse(P_MREQ);
    pulse(P_BAR);
    for (int i = 0; i < 14; i++) pulse(P_MDONE);
    hold_check(3, "R11 one of 15 left");
    pulse(P_MDONE);
    expect_release("R11");
  endtask

  initial begin
    idle(1);
    t_reset_r1();
    t_empty_r2();
    t_instr_r3();
    t_mem_r4();
    t_touch_r5();
    t_second_r7();
    t_same_cycle_r8();
    t_underflow_r9();
    t_simul_r10();
    t_full_r11();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule